// File: doc/BRIEF.md
# Vector Operand Swizzle and Result Routing Stage

This block sits in front of a four-component vector ALU. It reads up to three source operands and returns the result to the right place. For each source it takes a base register index from the instruction. It may add a relative offset to that index, and it then decodes the sum into a register class and a local index. These drive the register-file read ports in the same cycle. The block receives the read data, reorders the four components as the operand descriptor says, and may flip their signs. It then registers the three prepared operand vectors for the ALU.

Two other jobs share the same stage. The first is the two-bit condition register, which a compare instruction updates from the prepared sources. The second is the result path. It takes a finished result, a destination index and a component mask, and it produces registered write enables for the output-register bank or the temporary bank. When a scalar or dot-product result arrives, its component 0 is copied to every lane. The floating-point arithmetic and the descriptor table are outside this block.

Top module: `vec_operand_router`

## Requirements
- R1: A source's effective index E (base plus any offset) is decoded as follows. E from 0 to 15 is the input class (code 0) with local index E. E from 16 to 31 is the temporary class (code 1) with index E-16. E from 32 to 127 is the uniform class (code 2) with index E-32. A negative E, or E above 127, gives code 3 with index 0, and that operand then reads as the all-zero vector whatever the read port returns. Class and index appear combinationally in the cycle the base and offset inputs are applied.
- R2: The descriptor is 27 bits, and source s (0..2) owns bits 9s+8..9s. Within that field, the two bits at 9s+1+2k name which read component (0..3) becomes operand component k.
- R3: Bit 9s of the descriptor negates source s. The most significant bit of each of its four components is inverted after reordering.
- R4: The offset selector picks the offset. 0 means no offset. 1 means the first address register (two's complement). 2 means the second address register (two's complement). 3 means the loop counter (unsigned).
- R5: In two-source forms the offset goes to source 1 when the form code is 0 (normal) and to source 2 when the form code is 1 (inverted).
- R6: In three-source forms the offset goes to source 2 when the form code is 2 (normal) and to source 3 when the form code is 3 (inverted). Source 1 is never offset in these forms.
- R7: A valid result with a destination below 0x10 writes the output bank. A destination from 0x10 to 0x1F writes the temporary bank. A destination of 0x20 or above writes nothing. The write index is the low four bits of the destination.
- R8: Each write-enable bit k is set only when the result is valid and mask bit k is 1. With no valid result, both enable groups are zero.
- R9: When broadcast is requested, every component of the write data equals component 0 of the result. Otherwise the write data equals the result.
- R10: With compare enabled, condition bit 0 compares component 0 of prepared sources 1 and 2 using the x type, and bit 1 compares component 1 using the y type. The type codes are 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater and 5 greater-or-equal. Components are compared as sign-magnitude numbers, and +0 equals -0.
- R11: Compare types 6 and 7 leave their condition bit unchanged. With compare disabled, both bits hold.
- R12: Operands, condition bits, write enables, write index and write data are registered. They show the effect of their inputs one clock later and are zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_form | input | 2 | Instruction form: 0/1 two-source normal/inverted, 2/3 three-source normal/inverted |
| ar_sel | input | 2 | Offset selector |
| ar0 | input | AW | First address register |
| ar1 | input | AW | Second address register |
| lc | input | AW | Loop counter |
| s1_base | input | IW | Source 1 base index |
| s2_base | input | IW | Source 2 base index |
| s3_base | input | IW | Source 3 base index |
| desc | input | 27 | Operand descriptor (selectors and negate bits) |
| s1_cls | output | 2 | Source 1 read class |
| s1_idx | output | IW | Source 1 read index |
| s1_rdata | input | 4*CW | Source 1 read data |
| s2_cls | output | 2 | Source 2 read class |
| s2_idx | output | IW | Source 2 read index |
| s2_rdata | input | 4*CW | Source 2 read data |
| s3_cls | output | 2 | Source 3 read class |
| s3_idx | output | IW | Source 3 read index |
| s3_rdata | input | 4*CW | Source 3 read data |
| s1_op | output | 4*CW | Prepared operand 1 |
| s2_op | output | 4*CW | Prepared operand 2 |
| s3_op | output | 4*CW | Prepared operand 3 |
| cmp_en | input | 1 | Compare instruction this cycle |
| cmp_x | input | 3 | Compare type for condition bit 0 |
| cmp_y | input | 3 | Compare type for condition bit 1 |
| cond | output | 2 | Condition bits |
| res_valid | input | 1 | Result present |
| res_dest | input | DW | Result destination index |
| res_mask | input | 4 | Component write mask |
| res_bcast | input | 1 | Copy component 0 to all lanes |
| res_data | input | 4*CW | Result vector |
| out_we | output | 4 | Output-bank component write enables |
| tmp_we | output | 4 | Temporary-bank component write enables |
| wr_idx | output | 4 | Write index within the bank |
| wr_data | output | 4*CW | Write data |

## Verification
Read class and index are combinational. The bench checks them one time step after each new set of inputs, before the next clock edge. Prepared operands, condition bits and all write-side outputs are due exactly one clock edge after their inputs. The behavioural reference computes these values when the inputs are applied and compares them just after the following rising edge. Reset values are checked while reset is held.

// File: rtl/vec_operand_router.sv
`timescale 1ns/1ps
module vec_operand_router #(
  parameter int CW = 24,
  parameter int IW = 7,
  parameter int DW = 7,
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      op_form,
  input  logic [1:0]      ar_sel,
  input  logic [AW-1:0]   ar0,
  input  logic [AW-1:0]   ar1,
  input  logic [AW-1:0]   lc,
  input  logic [IW-1:0]   s1_base,
  input  logic [IW-1:0]   s2_base,
  input  logic [IW-1:0]   s3_base,
  input  logic [26:0]     desc,
  output logic [1:0]      s1_cls,
  output logic [IW-1:0]   s1_idx,
  input  logic [4*CW-1:0] s1_rdata,
  output logic [1:0]      s2_cls,
  output logic [IW-1:0]   s2_idx,
  input  logic [4*CW-1:0] s2_rdata,
  output logic [1:0]      s3_cls,
  output logic [IW-1:0]   s3_idx,
  input  logic [4*CW-1:0] s3_rdata,
  output logic [4*CW-1:0] s1_op,
  output logic [4*CW-1:0] s2_op,
  output logic [4*CW-1:0] s3_op,
  input  logic            cmp_en,
  input  logic [2:0]      cmp_x,
  input  logic [2:0]      cmp_y,
  output logic [1:0]      cond,
  input  logic            res_valid,
  input  logic [DW-1:0]   res_dest,
  input  logic [3:0]      res_mask,
  input  logic            res_bcast,
  input  logic [4*CW-1:0] res_data,
  output logic [3:0]      out_we,
  output logic [3:0]      tmp_we,
  output logic [3:0]      wr_idx,
  output logic [4*CW-1:0] wr_data
);

  localparam int VW    = 4 * CW;
  localparam int EW    = ((IW > AW) ? IW : AW) + 2;
  localparam int UBASE = 32;
  localparam logic [1:0] CLS_IN   = 2'd0;
  localparam logic [1:0] CLS_TMP  = 2'd1;
  localparam logic [1:0] CLS_UNI  = 2'd2;
  localparam logic [1:0] CLS_NONE = 2'd3;

  logic [3*IW-1:0]        base_all;
  logic [3*VW-1:0]        rd_all;
  logic [5:0]             cls_all;
  logic [3*IW-1:0]        idx_all;
  logic [3*VW-1:0]        swz_all;
  logic signed [EW-1:0]   ofs;
  logic [2:0]             rel_hot;
  logic [1:0]             cond_nx;

  assign base_all = {s3_base, s2_base, s1_base};
  assign rd_all   = {s3_rdata, s2_rdata, s1_rdata};

  always_comb begin
    case (ar_sel)
      2'd1:    ofs = EW'($signed(ar0));
      2'd2:    ofs = EW'($signed(ar1));
      2'd3:    ofs = $signed(EW'(lc));
      default: ofs = '0;
    endcase
  end

  always_comb begin
    case (op_form)
      2'd0:    rel_hot = 3'b001;
      2'd1:    rel_hot = 3'b010;
      2'd2:    rel_hot = 3'b010;
      default: rel_hot = 3'b100;
    endcase
  end

  generate
    for (genvar g = 0; g < 3; g++) begin : g_src
      logic signed [EW-1:0] add;
      logic signed [EW-1:0] eff;
      logic [1:0]           c;
      logic [IW-1:0]        ix;
      logic [VW-1:0]        raw;
      logic [8:0]           fld;

      assign fld = desc[9*g +: 9];
      assign add = rel_hot[g] ? ofs : '0;
      assign eff = $signed({{(EW-IW){1'b0}}, base_all[g*IW +: IW]}) + add;

      always_comb begin
        c  = CLS_NONE;
        ix = '0;
        if (!eff[EW-1] && eff[EW-2:IW] == '0) begin
          if (eff[IW-1:4] == '0) begin
            c  = CLS_IN;
            ix = eff[IW-1:0];
          end else if (eff[IW-1:5] == '0) begin
            c  = CLS_TMP;
            ix = {{(IW-4){1'b0}}, eff[3:0]};
          end else begin
            c  = CLS_UNI;
            ix = eff[IW-1:0] - IW'(UBASE);
          end
        end
      end

      assign raw = (c == CLS_NONE) ? '0 : rd_all[g*VW +: VW];

      for (genvar k = 0; k < 4; k++) begin : g_lane
        assign swz_all[g*VW + k*CW +: CW] =
          raw[fld[1+2*k +: 2]*CW +: CW] ^ {fld[0], {(CW-1){1'b0}}};
      end

      assign cls_all[2*g +: 2]   = c;
      assign idx_all[g*IW +: IW] = ix;
    end
  endgenerate

  assign s1_cls = cls_all[1:0];
  assign s2_cls = cls_all[3:2];
  assign s3_cls = cls_all[5:4];
  assign s1_idx = idx_all[0 +: IW];
  assign s2_idx = idx_all[IW +: IW];
  assign s3_idx = idx_all[2*IW +: IW];

  function automatic logic signed [CW-1:0] sm_val(input logic [CW-1:0] x);
    logic signed [CW-1:0] m;
    m = $signed({1'b0, x[CW-2:0]});
    return x[CW-1] ? -m : m;
  endfunction

  function automatic logic cmp_bit(input logic [2:0] t, input logic [CW-1:0] a,
                                   input logic [CW-1:0] b, input logic keep);
    logic signed [CW-1:0] va;
    logic signed [CW-1:0] vb;
    va = sm_val(a);
    vb = sm_val(b);
    case (t)
      3'd0:    return va == vb;
      3'd1:    return va != vb;
      3'd2:    return va <  vb;
      3'd3:    return va <= vb;
      3'd4:    return va >  vb;
      3'd5:    return va >= vb;
      default: return keep;
    endcase
  endfunction

  assign cond_nx[0] = cmp_bit(cmp_x, swz_all[0 +: CW],  swz_all[VW +: CW],      cond[0]);
  assign cond_nx[1] = cmp_bit(cmp_y, swz_all[CW +: CW], swz_all[VW+CW +: CW],   cond[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= '0;
      s2_op   <= '0;
      s3_op   <= '0;
      cond    <= '0;
      out_we  <= '0;
      tmp_we  <= '0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      s1_op   <= swz_all[0 +: VW];
      s2_op   <= swz_all[VW +: VW];
      s3_op   <= swz_all[2*VW +: VW];
      if (cmp_en) cond <= cond_nx;
      out_we  <= (res_valid && res_dest[DW-1:4] == '0) ? res_mask : 4'd0;
      tmp_we  <= (res_valid && res_dest[DW-1:5] == '0 && res_dest[4]) ? res_mask : 4'd0;
      wr_idx  <= res_dest[3:0];
      wr_data <= res_bcast ? {4{res_data[CW-1:0]}} : res_data;
    end
  end

endmodule

module vec_operand_router_chk #(
  parameter int CW = 24,
  parameter int IW = 7,
  parameter int DW = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      s1_cls,
  input logic [26:0]     desc,
  input logic [4*CW-1:0] s1_op,
  input logic            cmp_en,
  input logic [1:0]      cond,
  input logic            res_valid,
  input logic [DW-1:0]   res_dest,
  input logic [3:0]      res_mask,
  input logic            res_bcast,
  input logic [4*CW-1:0] res_data,
  input logic [3:0]      out_we,
  input logic [3:0]      tmp_we,
  input logic [4*CW-1:0] wr_data
);

  // R1
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_cls == 2'd3 && !desc[0]) |=> (s1_op == '0));

  // R7
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|out_we) && (|tmp_we)));

  // R7
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_dest[DW-1:5] != '0) |=> (out_we == 4'd0 && tmp_we == 4'd0));

  // R8
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> (out_we == 4'd0 && tmp_we == 4'd0));

  // R8
  mask_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (((out_we | tmp_we) & ~$past(res_mask)) == 4'd0));

  // R9
  bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_bcast |=> (wr_data == {4{$past(res_data[CW-1:0])}}));

  // R11
  cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> $stable(cond));

endmodule

bind vec_operand_router vec_operand_router_chk #(.CW(CW), .IW(IW), .DW(DW)) u_chk (.*);

// File: tb/vec_operand_router_bench.sv
`timescale 1ns/1ps
module vec_operand_router_bench;
  localparam int CW = 24;
  localparam int IW = 7;
  localparam int DW = 7;
  localparam int AW = 8;
  localparam int VW = 4 * CW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [1:0]    op_form, ar_sel;
  logic [AW-1:0] ar0, ar1, lc;
  logic [IW-1:0] s1_base, s2_base, s3_base;
  logic [26:0]   desc;
  logic [1:0]    s1_cls, s2_cls, s3_cls;
  logic [IW-1:0] s1_idx, s2_idx, s3_idx;
  logic [VW-1:0] s1_rdata, s2_rdata, s3_rdata;
  logic [VW-1:0] s1_op, s2_op, s3_op;
  logic          cmp_en;
  logic [2:0]    cmp_x, cmp_y;
  logic [1:0]    cond;
  logic          res_valid, res_bcast;
  logic [DW-1:0] res_dest;
  logic [3:0]    res_mask;
  logic [VW-1:0] res_data;
  logic [3:0]    out_we, tmp_we, wr_idx;
  logic [VW-1:0] wr_data;

  vec_operand_router #(.CW(CW), .IW(IW), .DW(DW), .AW(AW)) u_vec_operand_router (.*);

  logic [VW-1:0] mem_in  [16];
  logic [VW-1:0] mem_tmp [16];
  logic [VW-1:0] mem_uni [96];

  function automatic logic [VW-1:0] mkvec(int c, int i);
    logic [VW-1:0] v;
    logic [CW-1:0] w;
    for (int k = 0; k < 4; k++) begin
      w = CW'(c * 65536 + i * 256 + k * 17 + 3);
      w[CW-1] = ((i + k) % 2 == 1);
      v[k*CW +: CW] = w;
    end
    return v;
  endfunction

  function automatic logic [VW-1:0] lookup(logic [1:0] c, logic [IW-1:0] i);
    if (c == 2'd0) return mem_in[i[3:0]];
    if (c == 2'd1) return mem_tmp[i[3:0]];
    if (c == 2'd2 && i < 96) return mem_uni[i];
    return {4{24'hA5C3E1}};
  endfunction

  assign s1_rdata = lookup(s1_cls, s1_idx);
  assign s2_rdata = lookup(s2_cls, s2_idx);
  assign s3_rdata = lookup(s3_cls, s3_idx);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [1:0] exp_cond = 2'b00;

  task automatic chk(input string rq, input string what, input logic [VW-1:0] act,
                     input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic int smv(logic [CW-1:0] x);
    int m;
    m = int'(x[CW-2:0]);
    return x[CW-1] ? -m : m;
  endfunction

  function automatic logic ref_cmp(logic [2:0] t, logic [CW-1:0] a, logic [CW-1:0] b, logic keep);
    int va, vb;
    va = smv(a);
    vb = smv(b);
    case (t)
      3'd0: return va == vb;
      3'd1: return va != vb;
      3'd2: return va < vb;
      3'd3: return va <= vb;
      3'd4: return va > vb;
      3'd5: return va >= vb;
      default: return keep;
    endcase
  endfunction

  function automatic logic [8:0] fld(logic neg, logic [7:0] sel);
    return {sel, neg};
  endfunction

  task automatic defaults();
    op_form = 0; ar_sel = 0; ar0 = 0; ar1 = 0; lc = 0;
    s1_base = 0; s2_base = 0; s3_base = 0;
    desc = {3{fld(1'b0, 8'hE4)}};
    cmp_en = 0; cmp_x = 0; cmp_y = 0;
    res_valid = 0; res_bcast = 0; res_dest = 0; res_mask = 0;
    res_data = 96'h123456_ABCDEF_0F1E2D_3C4B5A;
  endtask

  task automatic step(input string rq);
    int ofs, e, ec, ei, bse;
    bit rel;
    logic [VW-1:0] raw, op;
    logic [VW-1:0] nop [3];
    logic [8:0] f;
    logic [CW-1:0] c;
    logic [1:0] acls, ncond;
    logic [IW-1:0] aidx;
    logic [3:0] eo, et, ew;
    logic [VW-1:0] ed;
    #1;
    case (ar_sel)
      2'd1: ofs = int'($signed(ar0));
      2'd2: ofs = int'($signed(ar1));
      2'd3: ofs = int'(lc);
      default: ofs = 0;
    endcase
    for (int s = 0; s < 3; s++) begin
      bse  = (s == 0) ? int'(s1_base) : (s == 1) ? int'(s2_base) : int'(s3_base);
      acls = (s == 0) ? s1_cls : (s == 1) ? s2_cls : s3_cls;
      aidx = (s == 0) ? s1_idx : (s == 1) ? s2_idx : s3_idx;
      rel  = (op_form == 0 && s == 0) || ((op_form == 1 || op_form == 2) && s == 1) ||
             (op_form == 3 && s == 2);
      e = bse + (rel ? ofs : 0);
      if (e < 0 || e > 127) begin ec = 3; ei = 0; end
      else if (e < 16) begin ec = 0; ei = e; end
      else if (e < 32) begin ec = 1; ei = e - 16; end
      else begin ec = 2; ei = e - 32; end
      chk(rq, "read class", VW'(acls), VW'(ec));
      chk(rq, "read index", VW'(aidx), VW'(ei));
      if (ec == 0) raw = mem_in[ei];
      else if (ec == 1) raw = mem_tmp[ei];
      else if (ec == 2) raw = mem_uni[ei];
      else raw = '0;
      f = desc[9*s +: 9];
      for (int k = 0; k < 4; k++) begin
        c = raw[int'(f[1+2*k +: 2])*CW +: CW];
        if (f[0]) c[CW-1] = ~c[CW-1];
        op[k*CW +: CW] = c;
      end
      nop[s] = op;
    end
    ncond = exp_cond;
    if (cmp_en) begin
      ncond[0] = ref_cmp(cmp_x, nop[0][0 +: CW], nop[1][0 +: CW], exp_cond[0]);
      ncond[1] = ref_cmp(cmp_y, nop[0][CW +: CW], nop[1][CW +: CW], exp_cond[1]);
    end
    eo = (res_valid && int'(res_dest) < 16) ? res_mask : 4'd0;
    et = (res_valid && int'(res_dest) >= 16 && int'(res_dest) < 32) ? res_mask : 4'd0;
    ew = res_dest[3:0];
    ed = res_bcast ? {4{res_data[CW-1:0]}} : res_data;
    @(posedge clk);
    #1;
    exp_cond = ncond;
    chk(rq, "operand 1", s1_op, nop[0]);
    chk(rq, "operand 2", s2_op, nop[1]);
    chk(rq, "operand 3", s3_op, nop[2]);
    chk(rq, "cond", VW'(cond), VW'(exp_cond));
    chk(rq, "out_we", VW'(out_we), VW'(eo));
    chk(rq, "tmp_we", VW'(tmp_we), VW'(et));
    chk(rq, "wr_idx", VW'(wr_idx), VW'(ew));
    chk(rq, "wr_data", wr_data, ed);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem_in[i]  = mkvec(1, i);
      mem_tmp[i] = mkvec(2, i);
    end
    for (int i = 0; i < 96; i++) mem_uni[i] = mkvec(3, i);
    mem_tmp[0] = '0;

    defaults();
    rst_n = 0;
    res_valid = 1; res_mask = 4'hF; cmp_en = 1;
    repeat (2) @(posedge clk);
    #1;
    // R12: reset values
    chk("R12", "reset op1", s1_op, '0);
    chk("R12", "reset cond", VW'(cond), '0);
    chk("R12", "reset out_we", VW'(out_we), '0);
    chk("R12", "reset wr_data", wr_data, '0);
    defaults();
    rst_n = 1;
    @(posedge clk);
    #1;

    // R1: class decode and boundaries
    s1_base = 5;  s2_base = 20;  s3_base = 40;  step("R1");
    s1_base = 15; s2_base = 16;  s3_base = 31;  step("R1");
    s1_base = 32; s2_base = 127; s3_base = 0;   step("R1");

    // R2: reordering
    desc = {fld(0, 8'hFF), fld(0, 8'h00), fld(0, 8'h1B)};
    s1_base = 7; s2_base = 21; s3_base = 50; step("R2");
    desc = {fld(0, 8'h4E), fld(0, 8'hB1), fld(0, 8'h55)};
    step("R2");

    // R3: negation
    desc = {fld(1, 8'hE4), fld(0, 8'hE4), fld(1, 8'h1B)};
    step("R3");
    desc = {3{fld(1, 8'hE4)}};
    s1_base = 2; s2_base = 17; s3_base = 33; step("R3");
    desc = {3{fld(0, 8'hE4)}};

    // R4: offset sources
    s1_base = 5; s2_base = 6; s3_base = 7;
    ar_sel = 1; ar0 = 8'd3; ar1 = 8'd9; lc = 8'd20; step("R4");
    ar_sel = 2; ar1 = 8'hFE; step("R4");
    ar_sel = 3; lc = 8'd10; step("R4");
    ar_sel = 3; lc = 8'd200; step("R4");
    ar_sel = 0; step("R4");
    // R1: negative effective index reads as dummy
    ar_sel = 2; ar1 = 8'hF6; s1_base = 3; step("R1");

    // R5: two-source slot
    ar_sel = 1; ar0 = 8'd4; s1_base = 1; s2_base = 2; s3_base = 3;
    op_form = 0; step("R5");
    op_form = 1; step("R5");
    op_form = 1; ar0 = 8'hFC; s2_base = 20; step("R5");

    // R6: three-source slot
    ar0 = 8'd12;
    op_form = 2; step("R6");
    op_form = 3; step("R6");
    op_form = 3; ar_sel = 3; lc = 8'd125; step("R6");
    op_form = 0; ar_sel = 0;

    // R10: compare types over several data sets
    cmp_en = 1;
    for (int t = 0; t < 8; t++) begin
      cmp_x = 3'(t); cmp_y = 3'((t + 3) % 8);
      s1_base = 7'(1 + t); s2_base = 7'(2 + (t % 3));
      desc = {fld(0, 8'hE4), fld(t[0], 8'hE4), fld(t[1], 8'hE4)};
      step("R10");
    end
    s1_base = 4; s2_base = 4; desc = {3{fld(0, 8'hE4)}};
    cmp_x = 0; cmp_y = 1; step("R10");
    s1_base = 16; s2_base = 16;
    desc = {fld(0, 8'hE4), fld(0, 8'hE4), fld(1, 8'hE4)};
    cmp_x = 0; cmp_y = 3; step("R10");

    // R11: hold behaviour
    s1_base = 1; s2_base = 9; desc = {3{fld(0, 8'hE4)}};
    cmp_x = 6; cmp_y = 7; step("R11");
    cmp_en = 0; cmp_x = 1; cmp_y = 1; step("R11");
    cmp_en = 1; cmp_x = 1; cmp_y = 0; step("R11");
    cmp_en = 0; cmp_x = 0; cmp_y = 1; step("R11");

    // R7: destination ranges
    res_valid = 1; res_mask = 4'hF;
    res_dest = 7'h03; step("R7");
    res_dest = 7'h0F; step("R7");
    res_dest = 7'h10; step("R7");
    res_dest = 7'h1F; step("R7");
    res_dest = 7'h20; step("R7");
    res_dest = 7'h7F; step("R7");

    // R8: masks
    res_dest = 7'h05; res_mask = 4'h5; step("R8");
    res_dest = 7'h1A; res_mask = 4'hA; step("R8");
    res_mask = 4'h0; step("R8");
    res_valid = 0; res_mask = 4'hF; step("R8");

    // R9: broadcast
    res_valid = 1; res_dest = 7'h02; res_mask = 4'hF;
    res_bcast = 1; step("R9");
    res_data = 96'hFEDCBA_987654_321000_800001; step("R9");
    res_bcast = 0; step("R9");

    // R12: operands follow one edge later across back-to-back changes
    s1_base = 40; s2_base = 41; s3_base = 42; step("R12");
    s1_base = 0;  s2_base = 30; s3_base = 90; step("R12");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule